// File: doc/BRIEF.md
# Idle Cell Insertion Generator

This block sits in a cell transmit path between a byte-wide cell FIFO and the downstream header-check stage. It emits one byte per cycle on a valid/ready byte stream and flags the first byte of every 53-byte cell. When the FIFO cannot supply a cell, the block fills the stream with idle/unassigned cells. The header and the payload fill byte of these cells come from a small bank of programmable registers.

The choice between a FIFO cell and an idle cell is made only at cell boundaries. A FIFO cell is sent when the FIFO holds at least one complete cell. An idle cell is sent when the FIFO fill level is at or below a programmable almost-empty threshold. Between those two levels the block outputs nothing and waits for the partial cell to finish arriving. For each idle cell sent, a one-cycle event is given to an external 24-bit idle cell counter. Header-check byte computation is not done here.

The idle pattern is copied into a shadow set when an idle cell is chosen. Register writes made while an idle cell is on the wire therefore apply only from the next idle cell onward.

Top module: `idle_cell_gen`

## Requirements
- R1: Every cell is 53 accepted bytes long, and `out_sop` is high exactly on the first byte of each cell while `out_valid` is high.
- R2: Idle cell bytes 0 to 4 come from header registers at select codes 0 to 4. After reset these hold 0x00, 0x00, 0x00, 0x01 and 0x52.
- R3: Idle cell bytes 5 to 52 all equal the fill register at select code 5, which resets to 0x6A.
- R4: At a cell boundary, a FIFO cell is chosen when the effective FIFO level is 53 bytes or more. The threshold register is at select code 6, is 7 bits wide (write data bits 6:0) and resets to 14.
- R5: At a boundary where the effective level is below 53, an idle cell is chosen if the level is at or below the threshold. Otherwise `out_valid` stays low, and the choice is made again every cycle until one of the two conditions holds.
- R6: A cell always completes from the source it started with. At the last byte of a FIFO cell, the next choice uses the level minus the byte being read in that cycle.
- R7: FIFO cell bytes show `fifo_data` unchanged. `fifo_rd` is high exactly in cycles where a FIFO-sourced byte is accepted (`out_valid` and `out_ready`).
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sop` hold their values into the next cycle and no FIFO byte is read.
- R9: `idle_evt` is high for exactly one cycle, in the cycle where the last byte of an idle cell is accepted, and at no other time.
- R10: A register write (`cfg_we` with `cfg_sel` and `cfg_wdata`) takes effect on the next clock. Idle cells use the pattern copied when they were chosen, so a write during an idle cell changes only later idle cells. Select code 7 changes nothing.
- R11: A synchronous active-high reset clears `out_valid`, returns the sequencer to the waiting state and loads all register defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0-4 header, 5 fill, 6 threshold |
| cfg_wdata | input | 8 | Register write data |
| fifo_level | input | 8 | FIFO fill level in bytes |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pops the FIFO head byte |
| out_data | output | 8 | Transmit byte |
| out_valid | output | 1 | Transmit byte valid |
| out_sop | output | 1 | First byte of a cell |
| out_ready | input | 1 | Downstream accepts the byte |
| idle_evt | output | 1 | One pulse per idle cell sent |

## Verification
The bench sweeps the FIFO level across every value from 0 to 60 against thresholds of 0, 14, 52, 53 and 127. This exposes an off-by-one in the at-or-below comparison or in the complete-cell test, which would send an idle cell over a waiting cell or start a FIFO cell one byte short. It builds a last-byte case where the raw level is 53 but the effective level is 52. A design that ignored the byte being read would start a FIFO cell that underruns. It pushes a full cell and writes the pattern registers in the middle of an idle cell. A design that switched sources or used live register values mid-cell would splice or mix cells. A long stretch of irregular `out_ready` checks that bytes are neither dropped nor duplicated during stalls.

// File: rtl/icg_pkg.sv
package icg_pkg;

    localparam int HDR_BYTES = 5;
    localparam int HDR_IDX_W = $clog2(HDR_BYTES);
    localparam int SEL_W     = 3;
    localparam int SEL_FILL  = 5;
    localparam int SEL_THR   = 6;

    localparam logic [7:0] FILL_RST = 8'h6A;
    localparam int         THR_RST  = 14;

    typedef enum logic [1:0] {
        SRC_WAIT = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_IDLE = 2'd2
    } src_e;

    typedef struct packed {
        logic [HDR_BYTES-1:0][7:0] hdr;
        logic [7:0]                fill;
    } pattern_t;

    // Reset value of each idle header byte.
    function automatic logic [7:0] hdr_reset(int pos);
        case (pos)
            3:       return 8'h01;
            4:       return 8'h52;
            default: return 8'h00;
        endcase
    endfunction

    // Source decision at a cell boundary.
    function automatic src_e pick_source(int lvl, int thr, int cell_len);
        if (lvl >= cell_len) return SRC_FIFO;
        if (lvl <= thr)      return SRC_IDLE;
        return SRC_WAIT;
    endfunction

endpackage

// File: rtl/icg_cfg_regs.sv
module icg_cfg_regs
    import icg_pkg::*;
#(
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    output pattern_t         pat,
    output logic [THR_W-1:0] thr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HDR_BYTES; i++) begin
                pat.hdr[i] <= hdr_reset(i);
            end
            pat.fill <= FILL_RST;
            thr      <= THR_W'(THR_RST);
        end else if (we) begin
            for (int i = 0; i < HDR_BYTES; i++) begin
                if (sel == SEL_W'(i)) pat.hdr[i] <= wdata;
            end
            if (sel == SEL_W'(SEL_FILL)) pat.fill <= wdata;
            if (sel == SEL_W'(SEL_THR))  thr      <= wdata[THR_W-1:0];
        end
    end

endmodule

// File: rtl/icg_cell_seq.sv
module icg_cell_seq
    import icg_pkg::*;
#(
    parameter int CELL_LEN = 53,
    parameter int LVL_W    = 8,
    parameter int THR_W    = 7,
    parameter int IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [THR_W-1:0] thr,
    input  pattern_t         pat_live,
    input  logic             out_ready,
    output src_e             src,
    output logic [IDX_W-1:0] idx,
    output pattern_t         pat_snap,
    output logic             fifo_rd,
    output logic             cell_done
);

    logic             accept;
    logic             at_last;
    logic [LVL_W-1:0] lvl_eff;
    src_e             choice;

    assign accept    = (src != SRC_WAIT) && out_ready;
    assign at_last   = (idx == IDX_W'(CELL_LEN - 1));
    assign fifo_rd   = (src == SRC_FIFO) && accept;
    assign cell_done = accept && at_last;
    // The byte popped this cycle no longer counts toward the next cell.
    assign lvl_eff   = fifo_level - LVL_W'(fifo_rd);
    assign choice    = pick_source(int'(lvl_eff), int'(thr), CELL_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            src      <= SRC_WAIT;
            idx      <= '0;
            pat_snap <= '0;
        end else if ((src == SRC_WAIT) || cell_done) begin
            src <= choice;
            idx <= '0;
            if (choice == SRC_IDLE) pat_snap <= pat_live;
        end else if (accept) begin
            idx <= idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/icg_byte_mux.sv
module icg_byte_mux
    import icg_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  src_e             src,
    input  logic [IDX_W-1:0] idx,
    input  pattern_t         snap,
    input  logic [7:0]       fifo_data,
    output logic [7:0]       data,
    output logic             valid,
    output logic             sop
);

    logic [HDR_IDX_W-1:0] hsel;

    assign hsel  = idx[HDR_IDX_W-1:0];
    assign valid = (src != SRC_WAIT);
    assign sop   = valid && (idx == '0);

    always_comb begin
        if (src == SRC_FIFO) begin
            data = fifo_data;
        end else if (src == SRC_IDLE) begin
            if (idx < IDX_W'(HDR_BYTES)) data = snap.hdr[hsel];
            else                         data = snap.fill;
        end else begin
            data = 8'h00;
        end
    end

endmodule

// File: rtl/idle_cell_gen.sv
module idle_cell_gen
    import icg_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 48,
    parameter int LVL_W         = 8,
    parameter int THR_W         = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [7:0]       fifo_data,
    output logic             fifo_rd,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_sop,
    input  logic             out_ready,
    output logic             idle_evt
);

    localparam int CELL_LEN = HDR_BYTES + PAYLOAD_BYTES;
    localparam int IDX_W    = $clog2(CELL_LEN);

    pattern_t         pat_live;
    pattern_t         pat_snap;
    logic [THR_W-1:0] thr;
    src_e             src;
    logic [IDX_W-1:0] idx;
    logic             cell_done;

    icg_cfg_regs #(.THR_W(THR_W)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .pat   (pat_live),
        .thr   (thr)
    );

    icg_cell_seq #(
        .CELL_LEN (CELL_LEN),
        .LVL_W    (LVL_W),
        .THR_W    (THR_W),
        .IDX_W    (IDX_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .fifo_level (fifo_level),
        .thr        (thr),
        .pat_live   (pat_live),
        .out_ready  (out_ready),
        .src        (src),
        .idx        (idx),
        .pat_snap   (pat_snap),
        .fifo_rd    (fifo_rd),
        .cell_done  (cell_done)
    );

    icg_byte_mux #(.IDX_W(IDX_W)) mux_i (
        .src       (src),
        .idx       (idx),
        .snap      (pat_snap),
        .fifo_data (fifo_data),
        .data      (out_data),
        .valid     (out_valid),
        .sop       (out_sop)
    );

    assign idle_evt = cell_done && (src == SRC_IDLE);

endmodule

// File: rtl/idle_cell_gen_chk.sv
module idle_cell_gen_chk #(
    parameter int CELL_LEN = 53
) (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_sop,
    input logic [7:0] out_data,
    input logic       fifo_rd,
    input logic       idle_evt
);

    localparam int CW = $clog2(CELL_LEN);

    logic [CW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt <= '0;
        end else if (out_valid && out_ready) begin
            bcnt <= (bcnt == CW'(CELL_LEN - 1)) ? '0 : bcnt + CW'(1);
        end
    end

    assert_sop_position_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sop == (bcnt == '0)));

    assert_sop_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);

    assert_read_on_accept_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (out_valid && out_ready));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)));

    assert_idle_evt_last_R9: assert property (@(posedge clk) disable iff (rst)
        idle_evt |-> (out_valid && out_ready && !fifo_rd && (bcnt == CW'(CELL_LEN - 1))));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind idle_cell_gen idle_cell_gen_chk #(.CELL_LEN(53)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_data  (out_data),
    .fifo_rd   (fifo_rd),
    .idle_evt  (idle_evt)
);

// File: tb/idle_cell_gen_tb_top.sv
`timescale 1ns/1ps
module idle_cell_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] fifo_level = 8'd0;
    logic [7:0] fifo_data = 8'd0;
    logic       fifo_rd;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_sop;
    logic       out_ready = 1'b1;
    logic       idle_evt;

    always #10 clk = ~clk;

    idle_cell_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .fifo_level (fifo_level),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_ready  (out_ready),
        .idle_evt   (idle_evt)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string ovr = "";

    // Reference model state (0 wait, 1 fifo, 2 idle)
    int m_src = 0, m_idx = 0;
    int m_hdr [5];
    int m_fill = 'h6A, m_thr = 14;
    int s_hdr [5];
    int s_fill = 0;
    int cnt = 0, head = 0;
    bit known = 0;
    int p_valid = 0, p_ready = 1, p_data = 0, p_sop = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input int act, input int exp);
        string tag;
        tag = (ovr != "") ? ovr : req;
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int decide(input int lvl, input int thr);
        if (lvl >= 53) return 1;
        if (lvl <= thr) return 2;
        return 0;
    endfunction

    task automatic model_reset();
        m_src = 0; m_idx = 0;
        m_hdr[0] = 0; m_hdr[1] = 0; m_hdr[2] = 0; m_hdr[3] = 'h01; m_hdr[4] = 'h52;
        m_fill = 'h6A; m_thr = 14;
    endtask

    task automatic step(input int push = 0, input bit rdy = 1, input bit wr = 0,
                        input int sel = 0, input int wd = 0);
        int ev, es, ed, erd, eevt, d;
        out_ready  = rdy;
        cfg_we     = wr;
        cfg_sel    = 3'(sel);
        cfg_wdata  = 8'(wd);
        fifo_level = 8'(cnt);
        fifo_data  = 8'(head);
        @(negedge clk);
        ev   = (m_src != 0) ? 1 : 0;
        es   = (ev == 1 && m_idx == 0) ? 1 : 0;
        ed   = (m_src == 1) ? head : ((m_idx < 5) ? s_hdr[m_idx % 5] : s_fill);
        erd  = (m_src == 1 && rdy) ? 1 : 0;
        eevt = (m_src == 2 && rdy && m_idx == 52) ? 1 : 0;
        if (known && !rst) begin
            chk((m_src == 1) ? "R4" : "R5", int'(out_valid), ev);
            if (ev == 1) begin
                chk("R1", int'(out_sop), es);
                chk((m_src == 1) ? "R7" : ((m_idx < 5) ? "R2" : "R3"), int'(out_data), ed);
            end
            chk("R7", int'(fifo_rd), erd);
            chk("R9", int'(idle_evt), eevt);
            if (p_valid == 1 && p_ready == 0) begin
                chk("R8", int'(out_valid), 1);
                chk("R8", int'(out_data), p_data);
                chk("R8", int'(out_sop), p_sop);
            end
        end
        p_valid = rst ? 0 : int'(out_valid);
        p_ready = int'(rdy);
        p_data  = int'(out_data);
        p_sop   = int'(out_sop);
        if (rst) begin
            model_reset();
            known = 1;
        end else if (known) begin
            if (m_src == 0 || (ev == 1 && rdy && m_idx == 52)) begin
                d = decide(cnt - erd, m_thr);
                if (d == 2) begin
                    for (int i = 0; i < 5; i++) s_hdr[i] = m_hdr[i];
                    s_fill = m_fill;
                end
                m_src = d;
                m_idx = 0;
            end else if (ev == 1 && rdy) begin
                m_idx++;
            end
            if (wr) begin
                if (sel < 5) m_hdr[sel] = wd;
                else if (sel == 5) m_fill = wd;
                else if (sel == 6) m_thr = wd & 127;
            end
            if (erd == 1) begin
                cnt--;
                head = (head + 1) & 255;
            end
            cnt += push;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_src(input int s);
        for (int k = 0; k < 200 && m_src != s; k++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        run(3);
        rst = 1'b0;

        // R11: first cycle after reset waits, then default idle cells
        ovr = "R11";
        run(60);
        ovr = "";
        run(106);

        // R6: a full cell arrives mid idle cell; idle cell must complete
        ovr = "R6";
        run(10);
        step(53);
        run(150);

        // R6: raw level 53 at last FIFO byte, effective 52 -> wait
        step(53);
        wait_src(1);
        step(52);
        run(80);
        step(1);
        run(120);

        // R6: two cells queued back to back
        step(106);
        run(200);

        // R5: level between threshold and a full cell holds output idle
        ovr = "R5";
        wait_src(2);
        step(20);
        run(70);
        step(33);
        run(120);

        // R10: register writes during an idle cell
        ovr = "R10";
        wait_src(2);
        run(3);
        step(0, 1, 1, 0, 'hAA);
        step(0, 1, 1, 5, 'h33);
        step(0, 1, 1, 7, 'h77);
        step(0, 1, 1, 4, 'hC4);
        run(120);
        ovr = "";

        // R8: irregular ready with trickling pushes
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((lfsr[3:0] < 4'd3 && cnt < 200) ? 1 : 0, lfsr[5] | lfsr[9]);
        end

        // R4/R5: threshold and level sweep
        foreach (lfsr[b]) begin end
        for (int t = 0; t < 5; t++) begin
            int thr_v;
            thr_v = (t == 0) ? 0 : (t == 1) ? 14 : (t == 2) ? 52 : (t == 3) ? 53 : 127;
            step(0, 1, 1, 6, thr_v);
            for (int lvl = 0; lvl <= 60; lvl++) begin
                for (int k = 0; k < 60 && m_src == 1; k++) step();
                cnt = lvl;
                run(55);
            end
        end

        run(60);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule